// File: doc/BRIEF.md
# SPI Host Request Framer

This block sits behind an SPI target's byte receiver and turns the bytes that arrive during one chip-select window into a single decoded host request. Chip select is active low. When it falls, the block arms and stores each received byte in a small buffer. Bytes arrive as a `rx_valid`/`rx_data` pair from a shift register that is outside this block.

The first three bytes form the header. If the first byte is at or above a configurable version base, the request uses the versioned layout: version, command and parameter count, with the parameters following. Any smaller first byte is the command code of a short legacy request, which has no parameters. Once the declared parameters have arrived, a one-cycle strobe presents the decoded fields. The stored bytes can be read back through a synchronous read port.

The request is abandoned if chip select rises early, or if a deadline counted from the moment of arming runs out. Either case raises a one-cycle abort pulse.

Top module: `spi_host_req_parser`

## Requirements
- R1: After reset, `cmd_valid` and `abort` are 0, and `cmd_version`, `cmd_code` and `cmd_param_len` are 0.
- R2: Arming happens only on a falling edge of `cs_n`. A byte offered while `cs_n` is high is not stored and produces no strobe.
- R3: When byte 0 is at or above `VER_BASE` (default 0xDC), a request reports version = byte 0 − `VER_BASE`, command = byte 1 and parameter count = byte 2.
- R4: When byte 0 is below `VER_BASE`, a request reports command = byte 0, version 0 and parameter count 0. It completes once three bytes have arrived.
- R5: `cmd_valid` is high for exactly one cycle. That cycle is the one after the edge that accepts byte number 3 + parameter count, and the strobe is never earlier.
- R6: If `cs_n` rises while the block is still waiting for bytes, `abort` pulses for one cycle one edge later, and no strobe is issued. `cmd_valid` and `abort` are never high together.
- R7: If the request is not complete after T = `CLK_FREQ_HZ`/1e6 × `TIMEOUT_US` cycles from the arming edge, `abort` pulses in the cycle after edge T, and no strobe is issued.
- R8: Byte i of the window is stored at buffer address i. `rd_data` returns `mem[rd_addr]` one cycle after `rd_addr` is applied.
- R9: Bytes at index `DEPTH` and beyond are not stored and do not wrap over earlier entries, but they still count towards completion.
- R10: After the strobe, further bytes in the same window are neither stored nor counted, and no second strobe occurs until `cs_n` has risen.
- R11: A rise of `cs_n` after the strobe or after an abort produces no abort pulse. The next falling edge starts a fresh request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select (synchronous to clk) |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_data | input | 8 | Received byte |
| rd_addr | input | $clog2(DEPTH) | Buffer read address |
| rd_data | output | 8 | Buffer read data, one cycle latency |
| cmd_valid | output | 1 | One-cycle strobe: request complete |
| cmd_version | output | 8 | Decoded version |
| cmd_code | output | 8 | Decoded command code |
| cmd_param_len | output | 8 | Decoded parameter count |
| abort | output | 1 | One-cycle pulse: request abandoned |

## Verification
The table of headers covers several cases. It includes a versioned header with a zero parameter count, which shows that completion happens at the header and not later. It includes versioned headers with nonzero counts, which show that the strobe waits for the last parameter. Legacy bytes just below the version base show that the format decision lies exactly at the base. A versioned header whose parameters end exactly at the buffer depth is also in the table. Directed frames separate a release-abort from a timeout-abort by checking the exact cycle of the pulse. An overlong frame is checked for the absence of wrap-around. Trailing bytes after completion are checked for having no effect on stored contents.

// File: rtl/spi_req_pkg.sv
package spi_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HDR   = 2'd1,
    ST_PARAM = 2'd2,
    ST_DONE  = 2'd3
  } req_state_e;

  localparam int CNT_W = 9;  // enough for 3 + 255 bytes
endpackage

// File: rtl/spi_req_buf.sv
module spi_req_buf #(
  parameter int DEPTH = 70,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spi_req_timer.sv
module spi_req_timer #(
  parameter int T_CYC = 8192,
  localparam int TW = $clog2(T_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  logic [TW-1:0] cnt;
  localparam logic [TW-1:0] LAST = TW'(T_CYC - 1);

  assign expired = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_req_fsm.sv
module spi_req_fsm
  import spi_req_pkg::*;
#(
  parameter int DEPTH    = 70,
  parameter int VER_BASE = 8'hDC,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          tmo,
  output logic          tmr_clear,
  output logic          tmr_run,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          cmd_valid,
  output logic [7:0]    cmd_version,
  output logic [7:0]    cmd_code,
  output logic [7:0]    cmd_param_len,
  output logic          abort
);
  localparam logic [7:0]       VB      = 8'(VER_BASE);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  req_state_e       st;
  logic             cs_q;
  logic [CNT_W-1:0] cnt, need;
  logic [7:0]       b0, b1;
  logic             waiting, take, versioned;
  logic [CNT_W-1:0] cnt_inc;

  assign waiting   = (st == ST_HDR) || (st == ST_PARAM);
  assign take      = waiting && !cs_n && rx_valid;
  assign cnt_inc   = cnt + 1'b1;
  assign versioned = (b0 >= VB);
  assign tmr_clear = (st == ST_IDLE);
  assign tmr_run   = waiting;
  assign wr_en     = take && (cnt < DEPTH_C);
  assign wr_addr   = cnt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      cs_q          <= 1'b1;
      cnt           <= '0;
      need          <= '0;
      b0            <= '0;
      b1            <= '0;
      cmd_valid     <= 1'b0;
      abort         <= 1'b0;
      cmd_version   <= '0;
      cmd_code      <= '0;
      cmd_param_len <= '0;
    end else begin
      cs_q      <= cs_n;
      cmd_valid <= 1'b0;
      abort     <= 1'b0;
      unique case (st)
        ST_IDLE: if (cs_q && !cs_n) begin
          st  <= ST_HDR;
          cnt <= '0;
        end
        ST_HDR, ST_PARAM: begin
          if (cs_n) begin
            abort <= 1'b1;
            st    <= ST_IDLE;
          end else if (rx_valid) begin
            cnt <= cnt_inc;
            if (st == ST_HDR) begin
              if (cnt == 0) b0 <= rx_data;
              if (cnt == 1) b1 <= rx_data;
              if (cnt == 2) begin
                if (versioned) begin
                  cmd_version   <= b0 - VB;
                  cmd_code      <= b1;
                  cmd_param_len <= rx_data;
                  need          <= CNT_W'(3) + CNT_W'(rx_data);
                end else begin
                  cmd_version   <= '0;
                  cmd_code      <= b0;
                  cmd_param_len <= '0;
                  need          <= CNT_W'(3);
                end
                if (!versioned || rx_data == 8'd0) begin
                  cmd_valid <= 1'b1;
                  st        <= ST_DONE;
                end else begin
                  st <= ST_PARAM;
                end
              end
            end else if (cnt_inc == need) begin
              cmd_valid <= 1'b1;
              st        <= ST_DONE;
            end
          end else if (tmo) begin
            abort <= 1'b1;
            st    <= ST_DONE;
          end
        end
        ST_DONE: if (cs_n) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_host_req_parser.sv
module spi_host_req_parser #(
  parameter int DEPTH       = 70,
  parameter int VER_BASE    = 8'hDC,
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int TIMEOUT_US  = 8192,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          cmd_valid,
  output logic [7:0]    cmd_version,
  output logic [7:0]    cmd_code,
  output logic [7:0]    cmd_param_len,
  output logic          abort
);
  localparam int TIMEOUT_CYC = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

  logic          tmo, tmr_clear, tmr_run, wr_en;
  logic [AW-1:0] wr_addr;

  spi_req_fsm #(.DEPTH(DEPTH), .VER_BASE(VER_BASE)) u_fsm (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tmo(tmo), .tmr_clear(tmr_clear), .tmr_run(tmr_run),
    .wr_en(wr_en), .wr_addr(wr_addr),
    .cmd_valid(cmd_valid), .cmd_version(cmd_version), .cmd_code(cmd_code),
    .cmd_param_len(cmd_param_len), .abort(abort)
  );

  spi_req_timer #(.T_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .clear(tmr_clear), .run(tmr_run), .expired(tmo)
  );

  spi_req_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(rx_data),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/spi_host_req_parser_chk.sv
module spi_host_req_parser_chk #(
  parameter int CLK_FREQ_HZ = 100_000_000,
  parameter int TIMEOUT_US  = 8192
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic cmd_valid,
  input logic abort
);
  localparam int T_CYC = (CLK_FREQ_HZ / 1_000_000) * TIMEOUT_US;

  logic        cs_prev, issued;
  logic [31:0] since_arm;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev   <= 1'b1;
      issued    <= 1'b0;
      since_arm <= '0;
    end else begin
      cs_prev <= cs_n;
      if (cs_prev && !cs_n) since_arm <= '0;
      else if (since_arm != 32'hFFFF_FFFF) since_arm <= since_arm + 1;
      if (cs_n) issued <= 1'b0;
      else if (cmd_valid) issued <= 1'b1;
    end
  end

  assert_cmd_single_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);
  assert_abort_single_R6: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && abort));
  assert_one_per_window_R10: assert property (@(posedge clk) disable iff (rst)
    issued |-> !cmd_valid);
  assert_timeout_late_R7: assert property (@(posedge clk) disable iff (rst)
    (abort && !$past(cs_n)) |-> (since_arm >= 32'(T_CYC)));
endmodule

bind spi_host_req_parser spi_host_req_parser_chk #(
  .CLK_FREQ_HZ(CLK_FREQ_HZ), .TIMEOUT_US(TIMEOUT_US)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .cmd_valid(cmd_valid), .abort(abort)
);

// File: tb/test_spi_host_req_parser.sv
`timescale 1ns/1ps
module test_spi_host_req_parser;
  localparam int DEPTH = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int T     = 40;

  logic          clk = 1'b0, rst = 1'b1, cs_n = 1'b1, rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data, cmd_version, cmd_code, cmd_param_len;
  logic          cmd_valid, abort;

  int n_tests = 0, n_fail = 0, cv_cnt = 0, ab_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_host_req_parser #(.DEPTH(DEPTH), .VER_BASE(8'hDC),
                        .CLK_FREQ_HZ(1_000_000), .TIMEOUT_US(T)) i_spi_host_req_parser (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_version(cmd_version), .cmd_code(cmd_code),
    .cmd_param_len(cmd_param_len), .abort(abort)
  );

  always @(posedge clk) begin
    #1;
    if (cmd_valid) cv_cnt++;
    if (abort) ab_cnt++;
  end

  // {byte0, byte1, byte2, exp_version, exp_code, exp_plen}
  localparam logic [47:0] VEC [6] = '{
    {8'hDC, 8'h12, 8'h00, 8'h00, 8'h12, 8'h00},
    {8'hDF, 8'h34, 8'h02, 8'h03, 8'h34, 8'h02},
    {8'hFF, 8'h56, 8'h03, 8'h23, 8'h56, 8'h03},
    {8'h05, 8'h99, 8'h88, 8'h00, 8'h05, 8'h00},
    {8'hDB, 8'h77, 8'h09, 8'h00, 8'hDB, 8'h00},
    {8'hDD, 8'h01, 8'h05, 8'h01, 8'h01, 8'h05}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic frame_start;
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic frame_end;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_addr = AW'(a);
    @(negedge clk); d = rd_data;
  endtask

  initial begin
    #400000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cv0, ab0, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 cmd_valid", cmd_valid, 0);
    chk("R1 abort", abort, 0);
    chk("R1 fields", {cmd_version, cmd_code, cmd_param_len}, 0);

    for (int i = 0; i < 6; i++) begin
      logic [7:0] b0, b1, b2, ev, ec, ep;
      {b0, b1, b2, ev, ec, ep} = VEC[i];
      frame_start();
      ab0 = ab_cnt;
      send(b0); send(b1);
      cv0 = cv_cnt;
      send(b2);
      if (ep != 0) begin
        chk("R5 no early strobe", cv_cnt, cv0);
        for (int k = 0; k < ep; k++) send(8'(8'h40 + i * 8 + k));
      end
      chk("R5 strobe on last byte", cmd_valid, 1);
      chk("R5 strobe count", cv_cnt, cv0 + 1);
      chk((b0 >= 8'hDC) ? "R3 versioned fields" : "R4 legacy fields",
          {cmd_version, cmd_code, cmd_param_len}, {ev, ec, ep});
      @(negedge clk);
      chk("R5 single cycle", cmd_valid, 0);
      rd(2, d);
      chk("R8 readback byte2", d, b2);
      if (ep != 0) begin
        rd(2 + ep, d);
        chk("R8 readback last param", d, 8'(8'h40 + i * 8 + ep - 1));
      end
      frame_end();
      chk("R11 no abort after strobe", ab_cnt, ab0);
    end

    // R2: byte offered with cs_n high is not stored
    cv0 = cv_cnt;
    send(8'h5A);
    rd(0, d);
    chk("R2 not stored while deselected", d, 8'hDD);
    chk("R2 no strobe while deselected", cv_cnt, cv0);

    // R10: trailing bytes after strobe ignored
    frame_start();
    send(8'h07); send(8'h11); send(8'h22);
    chk("R4 legacy code", cmd_code, 8'h07);
    cv0 = cv_cnt;
    send(8'h99); send(8'h98); send(8'h97);
    chk("R10 no second strobe", cv_cnt, cv0);
    rd(3, d);
    chk("R10 trailing byte not stored", d, 8'h68);
    frame_end();

    // R6: release before completion
    frame_start();
    cv0 = cv_cnt; ab0 = ab_cnt;
    send(8'hDC); send(8'h01); send(8'h03); send(8'hAA);
    frame_end();
    chk("R6 abort on release", ab_cnt, ab0 + 1);
    chk("R6 no strobe", cv_cnt, cv0);

    // R7: timeout with no bytes
    frame_start();
    cv0 = cv_cnt; ab0 = ab_cnt; n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk); n++;
      if (abort) break;
    end
    chk("R7 timeout cycle", n, T + 1);
    chk("R7 no strobe", cv_cnt, cv0);
    frame_end();
    chk("R11 no abort on release after timeout", ab_cnt, ab0 + 1);

    // R9: overlong frame, bytes beyond DEPTH dropped without wrap
    frame_start();
    cv0 = cv_cnt;
    send(8'hDC); send(8'h0A); send(8'h0A);
    for (int k = 3; k < 13; k++) send(8'(8'hB0 + k));
    chk("R9 strobe after 13 bytes", cv_cnt, cv0 + 1);
    chk("R9 plen", cmd_param_len, 8'h0A);
    rd(0, d);
    chk("R9 no wrap addr0", d, 8'hDC);
    rd(1, d);
    chk("R9 no wrap addr1", d, 8'h0A);
    rd(7, d);
    chk("R8 last stored byte", d, 8'hB7);
    frame_end();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule